// File: doc/BRIEF.md
# NAND Page Data Randomizer

This block whitens a byte stream on its way between a flash controller's page buffer and the flash bus. Each byte is combined by XOR with a keystream taken from a 15-bit linear feedback shift register. Scrambling and descrambling are the same operation, so one instance serves both writes and reads.

The keystream is not free-running. It is tied to the byte's position inside a flash page. A configuration pulse supplies a page number, a starting column and a layout mode. The block picks a seed for that page, derives a sub-seed for spare and ECC bytes where the layout calls for one, and steps the register forward one bit per clock until it reaches the requested column. Only then does it accept data.

While streaming, the block tracks the end of the current keystream region and a maximum burst length. At either point it re-runs the seek from the new column, which recovers the correct keystream for the next region. With no page configured, or past the end of page plus spare, bytes pass through unchanged.

Top module: `nand_page_randomizer`

## Requirements
- R1: The key register shifts right by one per step, and its new bit 14 is old bit 0 XOR old bit 1. Each accepted byte leaves as `in_data ^ key[7:0]`, taken before the register advances by 8 steps.
- R2: The page seed comes from a table indexed by page modulo the table size. The default table holds the single value 0x4A80, so any page's key at flat column 0 is 0x80.
- R3: In flat layout (`cfg_layout` = 0, and also 3), the key at column c is the page seed advanced by (c mod 4096) bytes. A start in the middle of a page therefore reproduces the keystream of a stream started at column 0.
- R4: The sub-seed is the page seed advanced by CHUNK_BYTES bytes.
- R5: In split layout (`cfg_layout` = 1), a data column c below PAGE_BYTES uses the page seed advanced by (c mod CHUNK_BYTES) bytes. The keystream restarts at every chunk boundary.
- R6: In split layout, a column c in the spare ECC area [PAGE_BYTES, PAGE_BYTES + (PAGE_BYTES/CHUNK_BYTES)·(ECC_BYTES+4)) uses the sub-seed advanced by ((c − PAGE_BYTES) mod (ECC_BYTES+4)) bytes. Spare columns beyond that area follow the flat rule.
- R7: In interleaved layout (`cfg_layout` = 2), sections are CHUNK_BYTES + PREPAD_BYTES + ECC_BYTES long. Within the sections, an offset r below CHUNK_BYTES uses the page seed advanced by r bytes. A larger offset uses the sub-seed advanced by r − CHUNK_BYTES bytes. Columns past the last section follow the flat rule.
- R8: After BURST_MAX bytes, or at the end of a keystream region, the block drops `in_ready` and re-seeks from the next column. The bytes that follow carry the key that R3 to R7 give for their column.
- R9: When configured with `cfg_page_none` = 1, every byte passes through unchanged.
- R10: Columns at or beyond PAGE_BYTES + SPARE_BYTES pass through unchanged.
- R11: `in_ready` is low in the cycle of `cfg_valid` and until the seek finishes. A new `cfg_valid` during a seek restarts it from the new settings.
- R12: After reset, and until the first configuration, `in_ready` and `out_valid` stay low.
- R13: Scrambling a stream and then scrambling the result again from the same page, column and layout returns the original bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | One-cycle pulse that loads the settings below |
| cfg_page_none | input | 1 | 1 = no page, pass bytes through |
| cfg_page | input | PAGE_W | Page number |
| cfg_column | input | COL_W | Starting byte column |
| cfg_layout | input | 2 | 0 flat, 1 split, 2 interleaved, 3 flat |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take a byte |
| out_data | output | 8 | Whitened byte |

## Verification
The assertions assume that `cfg_valid` is a single-cycle pulse and that the downstream side holds `out_ready` steady within a transfer. They also assume the seed table holds no zero entry, because the check that the key register never becomes zero depends on it. The bench keeps `out_ready` high and pulses `cfg_valid` for exactly one cycle. It uses only the default non-zero seed and raises `in_valid` only at falling edges. For every byte it predicts the key by direct stepping from the page seed for that column. The burst limit is shortened so that burst-boundary re-seeks happen inside one page.

// File: rtl/nrnd_pkg.sv
package nrnd_pkg;

  localparam int LFSR_W = 15;

  typedef logic [LFSR_W-1:0] lfsr_t;

  typedef enum logic [1:0] {
    LAY_FLAT        = 2'd0,
    LAY_SPLIT       = 2'd1,
    LAY_INTERLEAVED = 2'd2,
    LAY_RSVD        = 2'd3
  } layout_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_SEEK = 3'd2,
    ST_RUN  = 3'd3,
    ST_PASS = 3'd4
  } fsm_e;

  // single LFSR step: shift right, feedback of bits 0 and 1 into bit 14
  function automatic lfsr_t lfsr_step1(lfsr_t s);
    return {s[0] ^ s[1], s[LFSR_W-1:1]};
  endfunction

  // eight steps, one byte of keystream
  function automatic lfsr_t lfsr_step_byte(lfsr_t s);
    lfsr_t t;
    t = s;
    for (int i = 0; i < 8; i++) t = lfsr_step1(t);
    return t;
  endfunction

endpackage

// File: rtl/nrnd_seed_select.sv
module nrnd_seed_select
  import nrnd_pkg::*;
#(
  parameter int                        PAGE_W     = 16,
  parameter int                        SEED_COUNT = 1,
  parameter logic [SEED_COUNT*15-1:0]  SEED_TABLE = 15'h4A80
) (
  input  logic [PAGE_W-1:0] page,
  output lfsr_t             seed
);

  generate
    if (SEED_COUNT == 1) begin : g_single
      logic unused_page;
      assign unused_page = ^page;
      assign seed        = SEED_TABLE[14:0];
    end else begin : g_table
      localparam int IDX_W = $clog2(SEED_COUNT);
      logic [IDX_W-1:0] idx;
      assign idx  = IDX_W'(page % PAGE_W'(SEED_COUNT));
      assign seed = SEED_TABLE[idx*15 +: 15];
    end
  endgenerate

endmodule

// File: rtl/nrnd_region_map.sv
module nrnd_region_map
  import nrnd_pkg::*;
#(
  parameter int COL_W        = 12,
  parameter int PAGE_BYTES   = 256,
  parameter int SPARE_BYTES  = 32,
  parameter int CHUNK_BYTES  = 128,
  parameter int ECC_BYTES    = 8,
  parameter int PREPAD_BYTES = 4,
  parameter int SKIP_W       = 9,
  parameter int LEFT_W       = 9
) (
  input  logic [COL_W-1:0]  col,
  input  layout_e           layout,
  output logic              bypass,
  output logic              use_sub,
  output logic [SKIP_W-1:0] skip,
  output logic [LEFT_W-1:0] left
);

  localparam int unsigned TOTAL     = PAGE_BYTES + SPARE_BYTES;
  localparam int unsigned NBLK      = PAGE_BYTES / CHUNK_BYTES;
  localparam int unsigned SPARE_SEG = ECC_BYTES + 4;
  localparam int unsigned SPLIT_END = PAGE_BYTES + NBLK * SPARE_SEG;
  localparam int unsigned SECT      = CHUNK_BYTES + PREPAD_BYTES + ECC_BYTES;
  localparam int unsigned INTER_END = NBLK * SECT;
  localparam int unsigned WRAP      = 4096;
  localparam int unsigned PAGE_U    = PAGE_BYTES;
  localparam int unsigned CHUNK_U   = CHUNK_BYTES;

  int unsigned c;
  int unsigned r;
  int unsigned l;

  always_comb begin
    c       = 32'(col);
    bypass  = 1'b0;
    use_sub = 1'b0;
    r       = c % WRAP;
    l       = TOTAL - c;
    if (c >= TOTAL) begin
      bypass = 1'b1;
      r      = 0;
      l      = 1;
    end else begin
      case (layout)
        LAY_SPLIT: begin
          if (c < PAGE_U) begin
            r = c % CHUNK_U;
            l = CHUNK_U - r;
          end else if (c < SPLIT_END) begin
            r       = (c - PAGE_U) % SPARE_SEG;
            l       = SPARE_SEG - r;
            use_sub = 1'b1;
          end
        end
        LAY_INTERLEAVED: begin
          if (c < INTER_END) begin
            r = c % SECT;
            l = SECT - r;
            if (r >= CHUNK_U) begin
              r       = r - CHUNK_U;
              use_sub = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
    skip = SKIP_W'(r);
    left = LEFT_W'(l);
  end

endmodule

// File: rtl/nrnd_lfsr_core.sv
module nrnd_lfsr_core
  import nrnd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  lfsr_t load_val,
  input  logic  step_bit_en,
  input  logic  step_byte_en,
  output lfsr_t state
);

  lfsr_t state_d;

  always_comb begin
    state_d = state;
    if (load_en)           state_d = load_val;
    else if (step_bit_en)  state_d = lfsr_step1(state);
    else if (step_byte_en) state_d = lfsr_step_byte(state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 state <= '0;
    else if (load_en | step_bit_en | step_byte_en) state <= state_d;
  end

endmodule

// File: rtl/nand_page_randomizer.sv
module nand_page_randomizer
  import nrnd_pkg::*;
#(
  parameter int                        PAGE_W       = 16,
  parameter int                        COL_W        = 12,
  parameter int                        PAGE_BYTES   = 256,
  parameter int                        SPARE_BYTES  = 32,
  parameter int                        CHUNK_BYTES  = 128,
  parameter int                        ECC_BYTES    = 8,
  parameter int                        PREPAD_BYTES = 4,
  parameter int                        BURST_MAX    = 1024,
  parameter int                        SEED_COUNT   = 1,
  parameter logic [SEED_COUNT*15-1:0]  SEED_TABLE   = 15'h4A80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_page_none,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [COL_W-1:0]  cfg_column,
  input  logic [1:0]        cfg_layout,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data
);

  localparam int TOTAL   = PAGE_BYTES + SPARE_BYTES;
  localparam int SKIP_W  = $clog2(TOTAL);
  localparam int LEFT_W  = $clog2(TOTAL + 1);
  localparam int CNT_W   = $clog2((TOTAL + CHUNK_BYTES) * 8 + 1);
  localparam int BURST_W = $clog2(BURST_MAX + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fsm_e               st_q, st_d;
  logic [COL_W-1:0]   col_q, col_d;
  logic [PAGE_W-1:0]  page_q, page_d;
  layout_e            layout_q, layout_d;
  logic               nopage_q, nopage_d;
  logic [LEFT_W-1:0]  left_q, left_d;
  logic [BURST_W-1:0] burst_q, burst_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  lfsr_t              seed_w;
  lfsr_t              lfsr_w;
  logic               rg_bypass, rg_use_sub;
  logic [SKIP_W-1:0]  rg_skip;
  logic [LEFT_W-1:0]  rg_left;
  logic [CNT_W-1:0]   seek_bytes;
  logic               load_en, step_bit_en, step_byte_en;
  logic               active, fire, run_w;

  nrnd_seed_select #(
    .PAGE_W(PAGE_W), .SEED_COUNT(SEED_COUNT), .SEED_TABLE(SEED_TABLE)
  ) u_seed (
    .page(page_q), .seed(seed_w)
  );

  nrnd_region_map #(
    .COL_W(COL_W), .PAGE_BYTES(PAGE_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .CHUNK_BYTES(CHUNK_BYTES), .ECC_BYTES(ECC_BYTES),
    .PREPAD_BYTES(PREPAD_BYTES), .SKIP_W(SKIP_W), .LEFT_W(LEFT_W)
  ) u_map (
    .col(col_q), .layout(layout_q), .bypass(rg_bypass),
    .use_sub(rg_use_sub), .skip(rg_skip), .left(rg_left)
  );

  nrnd_lfsr_core u_lfsr (
    .clk(clk), .rst_n(rst_int_n), .load_en(load_en), .load_val(seed_w),
    .step_bit_en(step_bit_en), .step_byte_en(step_byte_en), .state(lfsr_w)
  );

  // byte path
  assign run_w     = (st_q == ST_RUN);
  assign active    = (run_w || st_q == ST_PASS) && !cfg_valid;
  assign in_ready  = active && out_ready;
  assign out_valid = active && in_valid;
  assign out_data  = in_data ^ (run_w ? lfsr_w[7:0] : 8'h00);
  assign fire      = in_valid && in_ready;

  // bytes to step: sub-seed derivation plus column offset
  assign seek_bytes = CNT_W'(rg_skip) + (rg_use_sub ? CNT_W'(CHUNK_BYTES) : '0);

  always_comb begin
    st_d         = st_q;
    col_d        = col_q;
    page_d       = page_q;
    layout_d     = layout_q;
    nopage_d     = nopage_q;
    left_d       = left_q;
    burst_d      = burst_q;
    cnt_d        = cnt_q;
    load_en      = 1'b0;
    step_bit_en  = 1'b0;
    step_byte_en = 1'b0;
    if (cfg_valid) begin
      st_d     = ST_LOAD;
      col_d    = cfg_column;
      page_d   = cfg_page;
      layout_d = layout_e'(cfg_layout);
      nopage_d = cfg_page_none;
    end else begin
      case (st_q)
        ST_LOAD: begin
          if (nopage_q || rg_bypass) begin
            st_d = ST_PASS;
          end else begin
            load_en = 1'b1;
            cnt_d   = seek_bytes << 3;
            left_d  = rg_left;
            burst_d = '0;
            st_d    = (seek_bytes == '0) ? ST_RUN : ST_SEEK;
          end
        end
        ST_SEEK: begin
          step_bit_en = 1'b1;
          cnt_d       = cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) st_d = ST_RUN;
        end
        ST_RUN: begin
          if (fire) begin
            step_byte_en = 1'b1;
            col_d        = col_q + 1'b1;
            left_d       = left_q - 1'b1;
            burst_d      = burst_q + 1'b1;
            if (left_q == LEFT_W'(1) || burst_q == BURST_W'(BURST_MAX - 1))
              st_d = ST_LOAD;
          end
        end
        ST_PASS: begin
          if (fire) col_d = col_q + 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q     <= ST_IDLE;
      col_q    <= '0;
      page_q   <= '0;
      layout_q <= LAY_FLAT;
      nopage_q <= 1'b1;
      left_q   <= '0;
      burst_q  <= '0;
      cnt_q    <= '0;
    end else begin
      st_q     <= st_d;
      col_q    <= col_d;
      page_q   <= page_d;
      layout_q <= layout_d;
      nopage_q <= nopage_d;
      left_q   <= left_d;
      burst_q  <= burst_d;
      cnt_q    <= cnt_d;
    end
  end

endmodule

// File: rtl/nand_page_randomizer_chk.sv
module nand_page_randomizer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_valid,
  input logic        cfg_page_none,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic [14:0] key_state,
  input logic        running
);

  logic cfg_seen_q;
  logic nopage_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_seen_q    <= 1'b0;
      nopage_seen_q <= 1'b0;
    end else if (cfg_valid) begin
      cfg_seen_q    <= 1'b1;
      nopage_seen_q <= cfg_page_none;
    end
  end

  p_idle_until_cfg_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_seen_q |-> (!in_ready && !out_valid));

  p_cfg_blocks_now_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !in_ready);

  p_cfg_blocks_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> !in_ready);

  p_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nopage_seen_q && out_valid) |-> (out_data == in_data));

  p_key_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && in_valid && in_ready) |=> !$stable(key_state));

  p_key_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (key_state != 15'h0));

  p_xfer_paired_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> in_ready);

endmodule

bind nand_page_randomizer nand_page_randomizer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_page_none(cfg_page_none),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .key_state(lfsr_w), .running(run_w)
);

// File: tb/nand_page_randomizer_tb_top.sv
module nand_page_randomizer_tb_top;

  localparam int PAGE  = 256;
  localparam int SPARE = 32;
  localparam int CHUNK = 128;
  localparam int ECCB  = 8;
  localparam int PRE   = 4;
  localparam int BURST = 20;
  localparam int TOTAL = PAGE + SPARE;
  localparam int NBLK  = PAGE / CHUNK;
  localparam int SEED  = 15'h4A80;

  logic        clk;
  logic        rst_n;
  logic        cfg_valid;
  logic        cfg_page_none;
  logic [15:0] cfg_page;
  logic [11:0] cfg_column;
  logic [1:0]  cfg_layout;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;

  int checks;
  int fails;
  logic [7:0] ref_key [0:127];

  nand_page_randomizer #(
    .PAGE_BYTES(PAGE), .SPARE_BYTES(SPARE), .CHUNK_BYTES(CHUNK),
    .ECC_BYTES(ECCB), .PREPAD_BYTES(PRE), .BURST_MAX(BURST)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_page_none(cfg_page_none),
    .cfg_page(cfg_page), .cfg_column(cfg_column), .cfg_layout(cfg_layout),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  function automatic int adv(int s, int nbytes);
    int t;
    t = s;
    for (int i = 0; i < nbytes * 8; i++)
      t = ((t >> 1) | (((t ^ (t >> 1)) & 1) << 14)) & 16'h7fff;
    return t;
  endfunction

  function automatic logic [7:0] model_key(int layout, bit nopage, int col);
    int base;
    int steps;
    int r;
    if (nopage || col >= TOTAL) return 8'h00;
    base  = SEED;
    steps = col % 4096;
    if (layout == 1) begin
      if (col < PAGE) steps = col % CHUNK;
      else if (col < PAGE + NBLK * (ECCB + 4)) begin
        steps = (col - PAGE) % (ECCB + 4);
        base  = adv(SEED, CHUNK);
      end
    end else if (layout == 2) begin
      if (col < NBLK * (CHUNK + PRE + ECCB)) begin
        r = col % (CHUNK + PRE + ECCB);
        if (r >= CHUNK) begin
          steps = r - CHUNK;
          base  = adv(SEED, CHUNK);
        end else steps = r;
      end
    end
    return 8'(adv(base, steps));
  endfunction

  // ---------------- helpers ----------------
  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic configure(int layout, bit nopage, int page, int col);
    cfg_valid     = 1'b1;
    cfg_layout    = 2'(layout);
    cfg_page_none = nopage;
    cfg_page      = 16'(page);
    cfg_column    = 12'(col);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q);
    in_valid = 1'b1;
    in_data  = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    q = out_data;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic stream_check(int layout, bit nopage, int page, int col, int n, string req);
    logic [7:0] d, q, e;
    configure(layout, nopage, page, col);
    for (int i = 0; i < n; i++) begin
      d = 8'((col + i) * 37 + 8'h5A);
      xfer(d, q);
      e = d ^ model_key(layout, nopage, col + i);
      check(q == e, req, q, e);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    in_valid = 1'b1;
    #1;
    check(!in_ready, "R12 ready", in_ready, 0);
    check(!out_valid, "R12 valid", out_valid, 0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_seed();
    logic [7:0] q;
    configure(0, 1'b0, 5, 0);
    xfer(8'h00, q);
    check(q == 8'h80, "R2 key page5 col0", q, 8'h80);
    configure(0, 1'b0, 9999, 0);
    xfer(8'h00, q);
    check(q == 8'h80, "R2 key page9999 col0", q, 8'h80);
  endtask

  task automatic t_flat_burst();
    logic [7:0] d, q;
    configure(0, 1'b0, 0, 0);
    for (int i = 0; i < 100; i++) begin
      d = 8'(i * 11);
      if (i == BURST) begin
        in_valid = 1'b1;
        #1;
        check(!in_ready, "R8 ready low at burst edge", in_ready, 0);
        @(negedge clk);
      end
      xfer(d, q);
      ref_key[i] = q ^ d;
      check(ref_key[i] == model_key(0, 1'b0, i), "R1 flat key", ref_key[i], model_key(0, 1'b0, i));
    end
  endtask

  task automatic t_mid_page();
    logic [7:0] d, q;
    configure(0, 1'b0, 3, 57);
    for (int i = 57; i < 90; i++) begin
      d = 8'(i * 3 + 1);
      xfer(d, q);
      check((q ^ d) == ref_key[i], "R3 mid start", q ^ d, ref_key[i]);
    end
  endtask

  task automatic t_subseed();
    logic [7:0] q, e;
    configure(1, 1'b0, 0, PAGE);
    xfer(8'h00, q);
    e = 8'(adv(SEED, CHUNK));
    check(q == e, "R4 sub-seed key", q, e);
  endtask

  task automatic t_roundtrip();
    logic [7:0] src [0:23];
    logic [7:0] mid [0:23];
    logic [7:0] q;
    int starts [0:2];
    starts[0] = 13; starts[1] = 250; starts[2] = 131;
    for (int k = 0; k < 3; k++) begin
      configure(k, 1'b0, k * 7, starts[k]);
      for (int i = 0; i < 24; i++) begin
        src[i] = 8'(i * 29 + k * 61 + 3);
        xfer(src[i], mid[i]);
      end
      configure(k, 1'b0, k * 7, starts[k]);
      for (int i = 0; i < 24; i++) begin
        xfer(mid[i], q);
        check(q == src[i], "R13 roundtrip", q, src[i]);
      end
    end
  endtask

  task automatic t_seek_gate();
    logic [7:0] q, e;
    configure(0, 1'b0, 0, 200);
    in_valid = 1'b1;
    repeat (100) @(negedge clk);
    #1;
    check(!in_ready, "R11 ready low during seek", in_ready, 0);
    in_valid = 1'b0;
    configure(0, 1'b0, 0, 3);
    xfer(8'hC3, q);
    e = 8'hC3 ^ model_key(0, 1'b0, 3);
    check(q == e, "R11 reconfig mid-seek", q, e);
  endtask

  // ---------------- main ----------------
  bit done;

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; cfg_valid = 1'b0; cfg_page_none = 1'b0; cfg_page = '0;
    cfg_column = '0; cfg_layout = '0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_seed();
    t_flat_burst();
    t_mid_page();
    t_subseed();
    stream_check(1, 1'b0, 0, 120, 16, "R5 split data");
    stream_check(1, 1'b0, 0, PAGE, 32, "R6 split spare");
    stream_check(2, 1'b0, 0, 120, 30, "R7 interleaved");
    stream_check(2, 1'b0, 0, 270, 18, "R7 interleaved tail");
    stream_check(0, 1'b1, 4, 10, 8, "R9 no page");
    stream_check(0, 1'b0, 0, 280, 16, "R10 beyond spare");
    t_roundtrip();
    t_seek_gate();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule